// File: doc/BRIEF.md
# Strobe-Activity Watchdog Supervisor

This block monitors a processor through a single strobe line. The processor shows that it is alive by toggling the strobe. Either a rising or a falling transition counts, and each one restarts an internal period timer. If the strobe holds one level for a whole timeout period, the active-low output `wdo_n_o` drops for a fixed number of cycles. That pulse also restarts the timer. An idle strobe therefore produces a steady train of pulses until the processor starts toggling again.

A 3-bit select input picks one of eight codes. Seven codes set the timeout period, and one code turns the supervisor off. After reset, and after any change of the select input, a startup delay runs before supervision begins. This gives the processor time to initialise. The startup delay equals the timeout period of the selected code. One select code can be configured by parameter to use a different startup rule: supervision then waits, with no time limit, for the first strobe transition.

The strobe passes through a two-flop synchronizer, so it may be asynchronous to `clk`. All period lengths are given in clock cycles through parameters. The control is a four-state machine:
- **STARTUP** counts the startup delay.
- **WAIT_EDGE** holds until the first strobe transition.
- **RUN** supervises the strobe.
- **PULSE** drives the output low.

The transitions are:
- **startup-done**: STARTUP to RUN.
- **first-edge-arm**: STARTUP to WAIT_EDGE.
- **first-edge-seen**: WAIT_EDGE to RUN.
- **timeout**: RUN to PULSE.
- **pulse-done**: PULSE to RUN.
- **restart**: any state to STARTUP, on a select change or the off code.

Top module: `wdog_supervisor`

## Requirements
- R1: In RUN, every transition of the synchronized strobe (either direction) clears the period timer, so `wdo_n_o` stays high while the strobe toggles more often than once per timeout period.
- R2: In RUN, if no strobe transition is seen for T cycles, `wdo_n_o` goes low. Counting the clock edges after a strobe change (edges 1 and 2 are synchronizer stages and edge 3 clears the timer), the fall occurs on edge T+3 after the last change.
- R3: Each low pulse of `wdo_n_o` lasts exactly PULSE_CYCLES cycles. Strobe transitions during the pulse do not shorten it.
- R4: When a pulse ends, the timer starts from zero. With an idle strobe, the next pulse follows after exactly T high cycles.
- R5: Select code 3'b011 disables supervision. `wdo_n_o` is high in every cycle that code is in force, including when it is applied in the middle of a pulse.
- R6: The timeout T is U×UNIT_CYCLES. U depends on the select code: 000→1, 001→10, 010→30, 100→100, 101→1000, 110→10000, 111→60000.
- R7: After reset release with an idle strobe, a startup delay of T cycles runs before RUN, so the first fall occurs on clock edge 2T+1. Strobe transitions during the startup delay have no effect.
- R8: When FIRST_EDGE_EN is 1 and the select equals FIRST_EDGE_CODE, no pulse is produced until the first strobe transition, however long the wait. After that transition, timing follows R2.
- R9: A change of the select input restarts the machine in STARTUP with the timer cleared. The next fall then occurs on edge 2T+1 (new T) after the change, if the strobe is idle.
- R10: During reset, `wdo_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_i | input | 1 | Processor activity strobe (may be asynchronous) |
| sel_i | input | 3 | Timing select code; 3'b011 disables |
| wdo_n_o | output | 1 | Active-low watchdog pulse output |

## Verification
The bench builds the block with UNIT_CYCLES=4, PULSE_CYCLES=5, FIRST_EDGE_EN=1 and FIRST_EDGE_CODE=3'b100. With these values, the codes 000, 001, 010, 100 and 101 give timeouts of 4, 40, 120, 400 and 4000 cycles. Every fall time can then be measured to the exact cycle within a short run. The longest code actually measured is 101, whose 4000-cycle timeout still finishes well inside the cycle limit. The short pulse width lets the bench watch several pulse trains, a strobe edge landing inside a pulse, and the off code arriving mid-pulse. Code 100 doubles as the first-edge code, so an idle wait of well over twice its timeout shows that the wait has no time limit.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        ST_STARTUP   = 2'd0,
        ST_WAIT_EDGE = 2'd1,
        ST_RUN       = 2'd2,
        ST_PULSE     = 2'd3
    } wd_state_e;

    localparam logic [2:0] SEL_OFF = 3'b011;

    // Timeout length in base units for each select code (0 for the off code).
    function automatic logic [31:0] units_for_code(input logic [2:0] code);
        logic [31:0] u;
        unique case (code)
            3'b000:  u = 32'd1;
            3'b001:  u = 32'd10;
            3'b010:  u = 32'd30;
            3'b011:  u = 32'd0;
            3'b100:  u = 32'd100;
            3'b101:  u = 32'd1000;
            3'b110:  u = 32'd10000;
            default: u = 32'd60000;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/wdog_sync_edge.sv
module wdog_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic edge_o
);
    logic [STAGES-1:0] chain_q;
    logic              hist_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= strobe_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], strobe_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= 1'b0;
        else        hist_q <= chain_q[STAGES-1];
    end

    assign edge_o = chain_q[STAGES-1] ^ hist_q;
endmodule

// File: rtl/wdog_period_sel.sv
module wdog_period_sel
    import wdog_pkg::*;
#(
    parameter int unsigned UNIT_CYCLES     = 1000,
    parameter int unsigned CNT_W           = 32,
    parameter bit          FIRST_EDGE_EN   = 1'b0,
    parameter logic [2:0]  FIRST_EDGE_CODE = 3'b110
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       sel_i,
    output logic             sel_chg_o,
    output logic             off_o,
    output logic             fe_mode_o,
    output logic [CNT_W-1:0] period_o
);
    logic [2:0]  sel_q;
    logic [63:0] prod;

    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= SEL_OFF;
        else        sel_q <= sel_i;
    end

    assign sel_chg_o = (sel_i != sel_q);
    assign off_o     = (sel_q == SEL_OFF);
    assign prod      = 64'(units_for_code(sel_q)) * 64'(UNIT_CYCLES);
    assign period_o  = prod[CNT_W-1:0];

    generate
        if (FIRST_EDGE_EN) begin : g_fe
            assign fe_mode_o = (sel_q == FIRST_EDGE_CODE);
        end else begin : g_no_fe
            assign fe_mode_o = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             hit_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_o <= '0;
        else if (clr_i) cnt_o <= '0;
        else            cnt_o <= cnt_o + CNT_W'(1);
    end

    assign hit_o = (cnt_o == (limit_i - CNT_W'(1)));
endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
    import wdog_pkg::*;
#(
    parameter int unsigned UNIT_CYCLES     = 1000,
    parameter int unsigned PULSE_CYCLES    = 200,
    parameter bit          FIRST_EDGE_EN   = 1'b0,
    parameter logic [2:0]  FIRST_EDGE_CODE = 3'b110,
    parameter int unsigned SYNC_STAGES     = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strobe_i,
    input  logic [2:0] sel_i,
    output logic       wdo_n_o
);
    localparam longint unsigned MAX_PERIOD = 64'(60000) * 64'(UNIT_CYCLES);
    localparam longint unsigned MAX_COUNT  =
        (MAX_PERIOD > 64'(PULSE_CYCLES)) ? MAX_PERIOD : 64'(PULSE_CYCLES);
    localparam int unsigned     CNT_W      = $clog2(MAX_COUNT + 1);

    wd_state_e        state_q, state_nx;
    logic             strobe_edge;
    logic             sel_chg, off, fe_mode;
    logic [CNT_W-1:0] period, limit, cnt;
    logic             hit, clr;

    wdog_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (strobe_i),
        .edge_o   (strobe_edge)
    );

    wdog_period_sel #(
        .UNIT_CYCLES     (UNIT_CYCLES),
        .CNT_W           (CNT_W),
        .FIRST_EDGE_EN   (FIRST_EDGE_EN),
        .FIRST_EDGE_CODE (FIRST_EDGE_CODE)
    ) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_i     (sel_i),
        .sel_chg_o (sel_chg),
        .off_o     (off),
        .fe_mode_o (fe_mode),
        .period_o  (period)
    );

    assign limit = (state_q == ST_PULSE) ? CNT_W'(PULSE_CYCLES) : period;

    wdog_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr),
        .limit_i (limit),
        .cnt_o   (cnt),
        .hit_o   (hit)
    );

    // Next-state and timer-clear decisions
    always_comb begin
        state_nx = state_q;
        clr      = 1'b0;
        if (sel_chg || off) begin
            state_nx = ST_STARTUP;                  // restart
            clr      = 1'b1;
        end else begin
            unique case (state_q)
                ST_STARTUP: begin
                    if (fe_mode) begin
                        state_nx = ST_WAIT_EDGE;    // first-edge-arm
                        clr      = 1'b1;
                    end else if (hit) begin
                        state_nx = ST_RUN;          // startup-done
                        clr      = 1'b1;
                    end
                end
                ST_WAIT_EDGE: begin
                    clr = 1'b1;
                    if (strobe_edge) state_nx = ST_RUN;  // first-edge-seen
                end
                ST_RUN: begin
                    if (strobe_edge) begin
                        clr = 1'b1;
                    end else if (hit) begin
                        state_nx = ST_PULSE;        // timeout
                        clr      = 1'b1;
                    end
                end
                ST_PULSE: begin
                    if (hit) begin
                        state_nx = ST_RUN;          // pulse-done
                        clr      = 1'b1;
                    end
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STARTUP;
        else        state_q <= state_nx;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) wdo_n_o <= 1'b1;
        else        wdo_n_o <= (state_nx != ST_PULSE);
    end

    // Assertions
    a_r1_edge_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && strobe_edge && !sel_chg && !off)
        |=> (state_q == ST_RUN && cnt == '0));

    a_r2_fall_from_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdo_n_o) |-> (state_q == ST_PULSE));

    a_r3_pulse_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE && !hit && !sel_chg && !off) |=> (state_q == ST_PULSE));

    a_r5_off_high: assert property (@(posedge clk) disable iff (!rst_n)
        off |-> wdo_n_o);

    a_r6_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        !off |-> (cnt < limit));

    a_r8_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_EDGE && !strobe_edge && !sel_chg && !off)
        |=> (state_q == ST_WAIT_EDGE));

    a_r9_sel_restart: assert property (@(posedge clk) disable iff (!rst_n)
        sel_chg |=> (state_q == ST_STARTUP && cnt == '0));
endmodule

// File: tb/wdog_supervisor_tb.sv
`timescale 1ns/1ps
module wdog_supervisor_tb;
    localparam int unsigned UNIT = 4;
    localparam int unsigned PW   = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strobe_i = 1'b0;
    logic [2:0] sel_i = 3'b000;
    logic       wdo_n_o;
    int         total = 0;
    int         fails = 0;

    always #2 clk = ~clk;

    wdog_supervisor #(
        .UNIT_CYCLES     (UNIT),
        .PULSE_CYCLES    (PW),
        .FIRST_EDGE_EN   (1'b1),
        .FIRST_EDGE_CODE (3'b100)
    ) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (strobe_i),
        .sel_i    (sel_i),
        .wdo_n_o  (wdo_n_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wait_fall(input int lim, output int n);
        n = 0;
        while (wdo_n_o && n < lim) begin tick(); n++; end
    endtask

    task automatic wait_rise(input int lim, output int n);
        n = 0;
        while (!wdo_n_o && n < lim) begin tick(); n++; end
    endtask

    task automatic do_reset(input logic [2:0] code);
        @(negedge clk);
        rst_n = 1'b0; sel_i = code; strobe_i = 1'b0;
        repeat (4) tick();
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        rst_n = 1'b0; sel_i = 3'b000;
        repeat (3) tick();
        check(wdo_n_o == 1'b1, "R10", "output during reset", int'(wdo_n_o), 1);
    endtask

    task automatic t_startup(input logic [2:0] code, input int t);
        int n;
        do_reset(code);
        wait_fall(3 * t + 20, n);
        check(n == 2 * t + 1, "R7", $sformatf("first fall, code %0d", code), n, 2 * t + 1);
    endtask

    task automatic t_startup_edges_ignored();
        int n;
        int extra;
        do_reset(3'b001);
        n = 0;
        for (int i = 0; i < 8; i++) begin
            strobe_i = ~strobe_i;
            repeat (3) begin tick(); n++; end
        end
        wait_fall(200, extra);
        check(n + extra == 81, "R7", "fall with edges in startup", n + extra, 81);
    endtask

    task automatic t_timeout(input logic [2:0] code, input int t);
        int n;
        do_reset(code);
        wait_fall(3 * t + 20, n);
        wait_rise(PW + 5, n);
        strobe_i = ~strobe_i;
        wait_fall(t + 20, n);
        check(n == t + 3, "R2", $sformatf("fall after last toggle, code %0d (R6)", code), n, t + 3);
    endtask

    task automatic t_pulse_train();
        int n;
        do_reset(3'b001);
        wait_fall(200, n);
        for (int k = 0; k < 2; k++) begin
            wait_rise(50, n);
            check(n == PW, "R3", "pulse width", n, PW);
            wait_fall(100, n);
            check(n == 40, "R4", "idle gap between pulses", n, 40);
        end
    endtask

    task automatic t_pulse_edge();
        int n;
        do_reset(3'b000);
        wait_fall(50, n);
        strobe_i = ~strobe_i;
        wait_rise(50, n);
        check(n == PW, "R3", "pulse width with edge inside", n, PW);
    endtask

    task automatic t_keepalive_then_restart();
        int lows;
        int n;
        do_reset(3'b001);
        lows = 0;
        for (int i = 0; i < 40; i++) begin
            strobe_i = ~strobe_i;
            repeat (10) begin tick(); if (!wdo_n_o) lows++; end
        end
        check(lows == 0, "R1", "low samples while toggling", lows, 0);
        sel_i = 3'b000;
        wait_fall(50, n);
        check(n == 9, "R9", "fall after select change", n, 9);
    endtask

    task automatic t_disabled();
        int lows;
        int n;
        do_reset(3'b011);
        lows = 0;
        repeat (2000) begin tick(); if (!wdo_n_o) lows++; end
        check(lows == 0, "R5", "low samples while off", lows, 0);
        do_reset(3'b000);
        wait_fall(50, n);
        sel_i = 3'b011;
        tick();
        check(wdo_n_o == 1'b1, "R5", "output after off code mid-pulse", int'(wdo_n_o), 1);
        sel_i = 3'b001;
        wait_fall(200, n);
        check(n == 81, "R9", "fall after leaving off code", n, 81);
    endtask

    task automatic t_first_edge();
        int lows;
        int n;
        do_reset(3'b100);
        lows = 0;
        repeat (1200) begin tick(); if (!wdo_n_o) lows++; end
        check(lows == 0, "R8", "low samples before first edge", lows, 0);
        strobe_i = ~strobe_i;
        wait_fall(600, n);
        check(n == 403, "R8", "fall after first edge", n, 403);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        t_reset_state();
        t_startup(3'b000, 4);
        t_startup(3'b001, 40);
        t_startup(3'b010, 120);
        t_startup_edges_ignored();
        t_timeout(3'b000, 4);
        t_timeout(3'b001, 40);
        t_timeout(3'b101, 4000);
        t_pulse_train();
        t_pulse_edge();
        t_keepalive_then_restart();
        t_disabled();
        t_first_edge();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule